// File: doc/BRIEF.md
# I2C Slave Address Recognition Engine

This block sits behind the pad synchronisers and glitch filters of an I2C slave. It watches the sampled clock and data lines and works out whether the bus master is addressing this device. It finds START, repeated START and STOP conditions. It shifts in address bytes MSB first and compares each byte against the enabled addresses. When a byte matches, it pulls SDA low during the acknowledge clock.

Three addresses are recognised:

- a primary own address, which is either a 7-bit address or a 10-bit address;
- a secondary 7-bit address, which is used only when dual addressing is enabled;
- the general call byte 0x00, which is used only when general call is enabled.

A 10-bit address arrives as a header byte followed by a byte holding the low eight address bits. Once the full address has matched, the block holds a matched flag and a direction flag. It can also emit a one-cycle event. It then stays silent until the next START or STOP.

Top module: `i2c_adr_match`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) clears `addr_hit`, `slave_tx` and any remembered 10-bit match, and releases SDA.
- R2: In 7-bit mode, the first byte after a START matches when bits 7..1 equal `own_addr[6:0]`. Bit 0 of that byte is the read/write bit, and `slave_tx` takes its value (1 means the slave transmits).
- R3: The secondary address `own_addr2` matches (bits 7..1 of the byte) only while `dual_en` is 1.
- R4: The byte 0x00 matches only while `gc_en` is 1. The byte 0x01 never matches as a general call.
- R5: After a byte that does not match, the block drives nothing and ignores every further byte until the next START.
- R6: On a match, `sda_pull` is asserted for the 9th SCL clock only when `ack_en` is 1. `addr_hit` is set whether or not acknowledge is enabled.
- R7: `addr_hit` is set at the SCL falling edge that ends the acknowledge clock. `addr_evt` pulses for exactly one cycle at that point, and only when `evt_en` is 1.
- R8: In 10-bit mode, a first byte equal to 11110 followed by `own_addr[9:8]` and a 0 is acknowledged as a header and does not set `addr_hit`. If the next byte equals `own_addr[7:0]`, the address matches with `slave_tx` = 0. Any other second byte is not acknowledged.
- R9: After a completed 10-bit match, a repeated START followed by the header with bit 0 set (11110, `own_addr[9:8]`, 1) matches with `slave_tx` = 1. The same read header is not acknowledged when no 10-bit match is remembered.
- R10: `sda_pull` changes only while SCL is low. It is released on the SCL falling edge that ends the acknowledge clock.
- R11: After reset, `sda_pull`, `addr_hit`, `addr_evt` and `slave_tx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised, filtered SCL level |
| sda_in | input | 1 | Synchronised, filtered SDA level |
| ten_bit_mode | input | 1 | 1 selects a 10-bit primary address |
| own_addr | input | 10 | Primary own address (bits 6..0 are used in 7-bit mode) |
| dual_en | input | 1 | Enables the secondary 7-bit address |
| own_addr2 | input | 7 | Secondary 7-bit address |
| gc_en | input | 1 | Enables general call recognition |
| ack_en | input | 1 | Enables the acknowledge pull-down |
| evt_en | input | 1 | Enables the match event pulse |
| sda_pull | output | 1 | 1 pulls SDA low |
| addr_hit | output | 1 | Address matched flag |
| addr_evt | output | 1 | One-cycle match event |
| slave_tx | output | 1 | Direction: 1 = slave transmitter |

## Verification
The byte comparison is driven with the following patterns:

- primary, secondary and general call bytes with each enable both on and off, which tells a correct comparison apart from one that ignores its enable;
- read and write variants of each address, which separates a correct direction flag from one that is stuck;
- the byte 0x01, which tells a true general call check apart from one that masks the read/write bit.

The 10-bit tests cover three sequences: header plus the correct low byte, header plus a wrong low byte, and a read header sent both after a completed match and after a STOP. Together these distinguish a remembered match from a bare header compare. A second byte sent with no START after a mismatch shows whether the block really goes quiet.

// File: rtl/i2c_adr_pkg.sv
package i2c_adr_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADR7_W   = 7;
  localparam int ADR10_W  = 10;
  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD
  } adr_state_e;

  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_HDR,
    HIT_FULL
  } adr_hit_e;
endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    scl_rise  = !scl_q && scl;
    scl_fall  = scl_q && !scl;
    start_det = scl_q && scl && sda_q && !sda;
    stop_det  = scl_q && scl && !sda_q && sda;
  end

  // R1: START and STOP can never be seen in the same cycle
  a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/i2c_adr_shift.sv
module i2c_adr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_q,
  output logic              full
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    cnt_d  = cnt_q;
    byte_d = byte_q;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en && !full) begin
      cnt_d  = cnt_q + 1'b1;
      byte_d = {byte_q[BYTE_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      byte_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
    end
  end

  assign full = (cnt_q == FULL_CNT);

  // R2: the bit counter never runs past one byte
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/i2c_adr_cmp.sv
module i2c_adr_cmp
  import i2c_adr_pkg::*;
(
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               second,
  input  logic               ten_bit,
  input  logic               ten_done,
  input  logic [ADR10_W-1:0] own_addr,
  input  logic [ADR7_W-1:0]  own_addr2,
  input  logic               dual_en,
  input  logic               gc_en,
  output adr_hit_e           hit,
  output logic               dir
);
  logic hdr_wr, hdr_rd, prim7, sec7, gcall, low10;

  always_comb begin
    hdr_wr = ten_bit && (rx_byte == {HDR10_TAG, own_addr[9:8], 1'b0});
    hdr_rd = ten_bit && ten_done && (rx_byte == {HDR10_TAG, own_addr[9:8], 1'b1});
    prim7  = !ten_bit && (rx_byte[7:1] == own_addr[ADR7_W-1:0]);
    sec7   = dual_en && (rx_byte[7:1] == own_addr2);
    gcall  = gc_en && (rx_byte == '0);
    low10  = ten_bit && (rx_byte == own_addr[7:0]);
    hit    = HIT_NONE;
    dir    = 1'b0;
    if (second) begin
      if (low10) hit = HIT_FULL;
    end else if (hdr_wr) begin
      hit = HIT_HDR;
    end else if (hdr_rd) begin
      hit = HIT_FULL;
      dir = 1'b1;
    end else if (prim7 || sec7 || gcall) begin
      hit = HIT_FULL;
      dir = rx_byte[0];
    end
  end
endmodule

// File: rtl/i2c_adr_match.sv
module i2c_adr_match
  import i2c_adr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               ten_bit_mode,
  input  logic [ADR10_W-1:0] own_addr,
  input  logic               dual_en,
  input  logic [ADR7_W-1:0]  own_addr2,
  input  logic               gc_en,
  input  logic               ack_en,
  input  logic               evt_en,
  output logic               sda_pull,
  output logic               addr_hit,
  output logic               addr_evt,
  output logic               slave_tx
);
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic scl_q, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_watch u_watch (
    .clk(clk), .rst_n(rst_q), .scl(scl_in), .sda(sda_in),
    .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic              sh_clr, sh_en, sh_full;
  logic [BYTE_W-1:0] rx_byte;

  i2c_adr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_q), .clr(sh_clr), .shift_en(sh_en),
    .bit_in(sda_in), .byte_q(rx_byte), .full(sh_full)
  );

  adr_state_e state_q, state_d;
  adr_hit_e   res_q, res_d, cmp_hit;
  logic       cmp_dir;
  logic       second_q, second_d, dir_q, dir_d, ten_done_q, ten_done_d;
  logic       hit_q, hit_d, tx_q, tx_d, evt_q, evt_d, pull_q, pull_d;

  i2c_adr_cmp u_cmp (
    .rx_byte(rx_byte), .second(second_q), .ten_bit(ten_bit_mode),
    .ten_done(ten_done_q), .own_addr(own_addr), .own_addr2(own_addr2),
    .dual_en(dual_en), .gc_en(gc_en), .hit(cmp_hit), .dir(cmp_dir)
  );

  always_comb begin
    state_d    = state_q;
    res_d      = res_q;
    second_d   = second_q;
    dir_d      = dir_q;
    ten_done_d = ten_done_q;
    hit_d      = hit_q;
    tx_d       = tx_q;
    pull_d     = pull_q;
    evt_d      = 1'b0;
    sh_clr     = 1'b0;
    sh_en      = 1'b0;
    if (stop_det) begin
      state_d    = ST_IDLE;
      hit_d      = 1'b0;
      tx_d       = 1'b0;
      ten_done_d = 1'b0;
      pull_d     = 1'b0;
    end else if (start_det) begin
      state_d  = ST_SHIFT;
      second_d = 1'b0;
      hit_d    = 1'b0;
      pull_d   = 1'b0;
      sh_clr   = 1'b1;
    end else begin
      unique case (state_q)
        ST_SHIFT: begin
          sh_en = scl_rise;
          if (scl_fall && sh_full) begin
            if (cmp_hit != HIT_NONE) begin
              state_d = ST_ACK;
              res_d   = cmp_hit;
              dir_d   = cmp_dir;
              pull_d  = ack_en;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            if (res_q == HIT_HDR) begin
              state_d  = ST_SHIFT;
              second_d = 1'b1;
              sh_clr   = 1'b1;
            end else begin
              state_d = ST_HOLD;
              hit_d   = 1'b1;
              tx_d    = dir_q;
              evt_d   = evt_en;
              if (second_q) ten_done_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q    <= ST_IDLE;
      res_q      <= HIT_NONE;
      second_q   <= 1'b0;
      dir_q      <= 1'b0;
      ten_done_q <= 1'b0;
      hit_q      <= 1'b0;
      tx_q       <= 1'b0;
      evt_q      <= 1'b0;
      pull_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      res_q      <= res_d;
      second_q   <= second_d;
      dir_q      <= dir_d;
      ten_done_q <= ten_done_d;
      hit_q      <= hit_d;
      tx_q       <= tx_d;
      evt_q      <= evt_d;
      pull_q     <= pull_d;
    end
  end

  assign sda_pull = pull_q;
  assign addr_hit = hit_q;
  assign addr_evt = evt_q;
  assign slave_tx = tx_q;

  // R10: the pull-down only moves while the registered SCL is low
  a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(pull_q) |-> !scl_q);
  // R6: a pull-down is only started with acknowledge enabled
  a_r6_pull_needs_ack_en: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(pull_q) |-> $past(ack_en));
  // R7: the event comes only with the flag and only when enabled
  a_r7_evt_with_hit: assert property (@(posedge clk) disable iff (!rst_q)
    evt_q |-> (hit_q && $past(evt_en)));
  // R1: a STOP leaves the flag clear and SDA released
  a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_q)
    stop_det |=> (!hit_q && !pull_q && !tx_q));
  // R5: nothing is driven while ignoring the bus
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_IDLE) |-> !pull_q);
endmodule

// File: tb/i2c_adr_match_test.sv
module i2c_adr_match_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ten_bit_mode = 1'b0, dual_en = 1'b0, gc_en = 1'b0, ack_en = 1'b1, evt_en = 1'b1;
  logic [9:0] own_addr = 10'h05A;
  logic [6:0] own_addr2 = 7'h33;
  logic sda_pull, addr_hit, addr_evt, slave_tx;
  logic sda_bus;
  int   n_chk = 0, n_bad = 0, evt_cnt = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull;

  i2c_adr_match uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .ten_bit_mode(ten_bit_mode), .own_addr(own_addr), .dual_en(dual_en),
    .own_addr2(own_addr2), .gc_en(gc_en), .ack_en(ack_en), .evt_en(evt_en),
    .sda_pull(sda_pull), .addr_hit(addr_hit), .addr_evt(addr_evt), .slave_tx(slave_tx)
  );

  always @(posedge clk) if (addr_evt) evt_cnt <= evt_cnt + 1;

  // vector: [14]dual [13]gc [12]ack [11]evt [10:3]byte [2]exp_ack [1]exp_hit [0]exp_tx
  localparam int NV = 10;
  localparam logic [14:0] VEC [0:NV-1] = '{
    {4'b0011, 8'hB4, 3'b110},  // R2 primary write
    {4'b0010, 8'hB5, 3'b111},  // R2 primary read, R7 event off
    {4'b0011, 8'h66, 3'b000},  // R3 secondary disabled
    {4'b1011, 8'h67, 3'b111},  // R3 secondary enabled, read
    {4'b0011, 8'h00, 3'b000},  // R4 general call disabled
    {4'b0111, 8'h00, 3'b110},  // R4 general call enabled
    {4'b0001, 8'hB4, 3'b010},  // R6 ack disabled, still a hit
    {4'b0011, 8'h12, 3'b000},  // R5 foreign address
    {4'b0111, 8'h01, 3'b000},  // R4 0x01 is not a general call
    {4'b1011, 8'h66, 3'b110}   // R3 secondary write
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic w;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; w(); m_scl = 1'b1; w(); m_sda = 1'b0; w(); m_scl = 1'b0; w();
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; w(); m_scl = 1'b1; w(); m_sda = 1'b1; w();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(); m_scl = 1'b1; w(); m_scl = 1'b0; w();
    end
  endtask

  task automatic ack_slot(output logic got);
    m_sda = 1'b1; w(); m_scl = 1'b1; w();
    got = !sda_bus;
    m_scl = 1'b0; w();
    chk("R10 released after 9th clock", int'(sda_pull), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic got;
    int   e0;
    repeat (3) @(negedge clk);
    chk("R11 sda_pull in reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 sda_pull", int'(sda_pull), 0);
    chk("R11 addr_hit", int'(addr_hit), 0);
    chk("R11 addr_evt", int'(addr_evt), 0);
    chk("R11 slave_tx", int'(slave_tx), 0);

    for (int v = 0; v < NV; v++) begin
      dual_en = VEC[v][14]; gc_en = VEC[v][13]; ack_en = VEC[v][12]; evt_en = VEC[v][11];
      e0 = evt_cnt;
      bus_start();
      send_byte(VEC[v][10:3]);
      ack_slot(got);
      chk("R2/R3/R4/R6 ack", int'(got), int'(VEC[v][2]));
      chk("R2/R3/R4/R5 addr_hit", int'(addr_hit), int'(VEC[v][1]));
      chk("R2 slave_tx", int'(slave_tx), int'(VEC[v][0]));
      chk("R7 event count", evt_cnt - e0, int'(VEC[v][1] & VEC[v][11]));
      bus_stop();
      chk("R1 stop clears hit", int'(addr_hit), 0);
      chk("R1 stop clears tx", int'(slave_tx), 0);
    end

    // R5: after a mismatch, own address without START is ignored
    dual_en = 1'b0; gc_en = 1'b0; ack_en = 1'b1; evt_en = 1'b1;
    bus_start();
    send_byte(8'h12); ack_slot(got);
    send_byte(8'hB4); ack_slot(got);
    chk("R5 no ack without START", int'(got), 0);
    chk("R5 no hit without START", int'(addr_hit), 0);
    // R1: a repeated START re-arms reception
    bus_start();
    send_byte(8'hB4); ack_slot(got);
    chk("R1 repeated START matches", int'(got), 1);
    chk("R1 hit after repeated START", int'(addr_hit), 1);
    bus_stop();

    // R10: pull-down held during high phase of 9th clock
    bus_start();
    send_byte(8'hB4);
    m_sda = 1'b1; w();
    chk("R10 pulled while SCL low", int'(sda_pull), 1);
    m_scl = 1'b1; w();
    chk("R10 pulled while SCL high", int'(sda_pull), 1);
    chk("R7 no hit before ack ends", int'(addr_hit), 0);
    m_scl = 1'b0; w();
    chk("R10 released", int'(sda_pull), 0);
    chk("R7 hit after ack ends", int'(addr_hit), 1);
    bus_stop();

    // R8/R9: 10-bit address 0x2C5 -> header 0xF4/0xF5, low byte 0xC5
    ten_bit_mode = 1'b1; own_addr = 10'h2C5;
    e0 = evt_cnt;
    bus_start();
    send_byte(8'hF4); ack_slot(got);
    chk("R8 header ack", int'(got), 1);
    chk("R8 header is no hit", int'(addr_hit), 0);
    send_byte(8'hC5); ack_slot(got);
    chk("R8 low byte ack", int'(got), 1);
    chk("R8 hit", int'(addr_hit), 1);
    chk("R8 receiver", int'(slave_tx), 0);
    bus_start();
    chk("R9 hit cleared by repeated START", int'(addr_hit), 0);
    send_byte(8'hF5); ack_slot(got);
    chk("R9 read header ack", int'(got), 1);
    chk("R9 hit", int'(addr_hit), 1);
    chk("R9 transmitter", int'(slave_tx), 1);
    chk("R7 two events", evt_cnt - e0, 2);
    bus_stop();
    chk("R1 stop clears 10-bit", int'(addr_hit), 0);
    bus_start();
    send_byte(8'hF5); ack_slot(got);
    chk("R9 read header without prior match", int'(got), 0);
    chk("R9 no hit", int'(addr_hit), 0);
    bus_stop();
    bus_start();
    send_byte(8'hF4); ack_slot(got);
    send_byte(8'hC4); ack_slot(got);
    chk("R8 wrong low byte no ack", int'(got), 0);
    chk("R8 wrong low byte no hit", int'(addr_hit), 0);
    bus_stop();
    // R8: 7-bit primary compare is off in 10-bit mode (0x45 from low bits)
    bus_start();
    send_byte(8'h8A); ack_slot(got);
    chk("R8 no 7-bit compare in 10-bit mode", int'(got), 0);
    bus_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule